// File: doc/BRIEF.md
# Power-on Self-Test Sequencer with ROM Signature

This block carries out a complete device self-test when a self-test command arrives with a destination address for the result. It first sends a one-cycle selective reset to the rest of the device. It then runs three checks one after another. The first check scans the internal ROM and folds every word into a 16-bit signature register. The second check writes two complementary patterns into each internal parallel register and reads each one back. The third check asks the serial subsystem to diagnose itself and waits for its verdict.

When the three checks are done, the sequencer packs the failure flags and the computed signature into one 32-bit word. It writes that word to the supplied address through a simple write port with a valid/ready handshake. It then pulses a full-reset output so the device goes back to its default configuration. The ROM, the register file, the diagnose unit and the memory master all sit outside this block.

Top module: `bist_seq`

## Requirements
- R1: A command is taken only while `busy` is low. The address latched from that command is the one used for the result write. A `cmd_valid` pulse while `busy` is high starts no second run and does not change the result address.
- R2: The first action of a run is a `sel_rst` pulse that lasts exactly one cycle. No ROM read, register access, diagnose request or result write happens before it.
- R3: The ROM is read once per address, from 0 up to ROM_DEPTH-1 in ascending order, with one read per cycle. Read data is expected one cycle after `rom_rd`.
- R4: The signature register starts at 0xFFFF before the first ROM word. For each word d it updates as s' = (s<<1) ^ (s[15] ? 0x1021 : 0) ^ d, which is the polynomial x^16+x^12+x^5+1. The ROM flag is set when the final signature differs from GOOD_SIG.
- R5: The register check starts after the last ROM read. It visits registers in ascending index order. For each register it does four accesses in this order: write 0x5555, read, write 0xAAAA, read. Read data arrives one cycle after `reg_re`, and any mismatch sets the register flag.
- R6: After the register check, `diag_req` stays high until `diag_ack` is seen. The diagnose flag takes the value of `diag_fail` in the ack cycle.
- R7: If no ack arrives within DIAG_TIMEOUT cycles of `diag_req`, the request drops after exactly DIAG_TIMEOUT cycles and the diagnose flag is set to 1.
- R8: Result word layout, where 1 means fail: bit 2 is the ROM flag, bit 3 is the register flag and bit 5 is the diagnose flag. Every other bit of 15:0 is 0 except bit 12.
- R9: Bit 12 of the result word is the OR of bits 2, 3 and 5.
- R10: Bits 31:16 of the result word hold the computed signature. The result word is presented on `mem_wr_*` only after the diagnose check, and it is written exactly once. `mem_wr_valid`, the address and the data stay unchanged until `mem_wr_ready`.
- R11: `full_rst` pulses for exactly one cycle, in the cycle after the write is accepted. `busy` is low in the cycle after that pulse.
- R12: After reset, `busy`, `sel_rst`, `rom_rd`, `reg_we`, `reg_re`, `diag_req`, `mem_wr_valid` and `full_rst` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Self-test command strobe |
| cmd_addr | input | ADDR_W | Destination address for the result word |
| busy | output | 1 | A self-test run is in progress |
| sel_rst | output | 1 | One-cycle selective reset pulse |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | ROM_AW | ROM word address |
| rom_data | input | 16 | ROM data, valid one cycle after `rom_rd` |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_sel | output | REG_AW | Register index |
| reg_wdata | output | 16 | Register write pattern |
| reg_rdata | input | 16 | Register read data, valid one cycle after `reg_re` |
| diag_req | output | 1 | Diagnose request, held until ack or timeout |
| diag_ack | input | 1 | Diagnose done |
| diag_fail | input | 1 | Diagnose verdict in the ack cycle, 1 means fail |
| mem_wr_valid | output | 1 | Result write request |
| mem_wr_addr | output | ADDR_W | Result write address |
| mem_wr_data | output | 32 | Packed result word |
| mem_wr_ready | input | 1 | Write accepted |
| full_rst | output | 1 | One-cycle full device reset pulse |

## Verification
The bench changes one ROM word and checks the result against a signature it computes on its own. A seed, tap or latency error would give a wrong upper half or raise the ROM flag on a clean ROM. It forces one register bit stuck at 1 so that only the 0xAAAA read-back fails; a design that only tried 0x5555 would report a pass. It also runs a diagnose unit that never answers: an off-by-one timeout would hold the request for 1023 or 1025 cycles, and a missing timeout would hang. The bench holds `mem_wr_ready` low so that a design which drops or changes the write would be caught, and it sends a stray command mid-run so that a design which reloads the address or restarts would be caught.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int SIG_W  = 16;
    localparam int WORD_W = 16;

    localparam logic [SIG_W-1:0]  SIG_POLY = 16'h1021;
    localparam logic [SIG_W-1:0]  SIG_SEED = 16'hFFFF;
    localparam logic [WORD_W-1:0] PAT_LO   = 16'h5555;
    localparam logic [WORD_W-1:0] PAT_HI   = 16'hAAAA;

    // bit positions in the packed result word
    localparam int BIT_ROM  = 2;
    localparam int BIT_REG  = 3;
    localparam int BIT_DIAG = 5;
    localparam int BIT_ALL  = 12;

    typedef struct packed {
        logic rom;
        logic regs;
        logic diag;
    } fail_flags_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SRST,
        ST_ROM,
        ST_ROM_WAIT,
        ST_ROM_CMP,
        ST_REGS,
        ST_DIAG,
        ST_WRITE,
        ST_FRST
    } seq_state_t;

    typedef enum logic [2:0] {
        RC_IDLE,
        RC_WR_LO,
        RC_RD_LO,
        RC_CMP_LO,
        RC_WR_HI,
        RC_RD_HI,
        RC_CMP_HI
    } rc_phase_t;

    function automatic logic [SIG_W-1:0] misr_step(input logic [SIG_W-1:0] s,
                                                   input logic [WORD_W-1:0] d);
        logic [SIG_W-1:0] shifted;
        shifted = {s[SIG_W-2:0], 1'b0};
        if (s[SIG_W-1]) begin
            shifted = shifted ^ SIG_POLY;
        end
        return shifted ^ d;
    endfunction

    function automatic logic [31:0] pack_result(input fail_flags_t f,
                                                input logic [SIG_W-1:0] sig);
        logic [31:0] w;
        w           = '0;
        w[31:16]    = sig;
        w[BIT_ROM]  = f.rom;
        w[BIT_REG]  = f.regs;
        w[BIT_DIAG] = f.diag;
        w[BIT_ALL]  = f.rom | f.regs | f.diag;
        return w;
    endfunction

endpackage

// File: rtl/bist_misr.sv
module bist_misr
    import bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic [SIG_W-1:0]  sig
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            sig <= SIG_SEED;
        end else if (shift) begin
            sig <= misr_step(sig, din);
        end
    end

endmodule

// File: rtl/bist_reg_check.sv
module bist_reg_check
    import bist_pkg::*;
#(
    parameter int REG_COUNT = 8,
    parameter int REG_AW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              reg_we,
    output logic              reg_re,
    output logic [REG_AW-1:0] reg_sel,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              done,
    output logic              fail
);

    localparam logic [REG_AW-1:0] LAST_IDX = REG_AW'(REG_COUNT - 1);

    rc_phase_t         phase;
    logic [REG_AW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= RC_IDLE;
            idx   <= '0;
            fail  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                RC_IDLE: begin
                    if (start) begin
                        phase <= RC_WR_LO;
                        idx   <= '0;
                        fail  <= 1'b0;
                    end
                end
                RC_WR_LO: phase <= RC_RD_LO;
                RC_RD_LO: phase <= RC_CMP_LO;
                RC_CMP_LO: begin
                    if (reg_rdata != PAT_LO) begin
                        fail <= 1'b1;
                    end
                    phase <= RC_WR_HI;
                end
                RC_WR_HI: phase <= RC_RD_HI;
                RC_RD_HI: phase <= RC_CMP_HI;
                RC_CMP_HI: begin
                    if (reg_rdata != PAT_HI) begin
                        fail <= 1'b1;
                    end
                    if (idx == LAST_IDX) begin
                        phase <= RC_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx   <= idx + 1'b1;
                        phase <= RC_WR_LO;
                    end
                end
                default: phase <= RC_IDLE;
            endcase
        end
    end

    always_comb begin
        reg_we    = (phase == RC_WR_LO) || (phase == RC_WR_HI);
        reg_re    = (phase == RC_RD_LO) || (phase == RC_RD_HI);
        reg_wdata = (phase == RC_WR_HI) ? PAT_HI : PAT_LO;
        reg_sel   = idx;
    end

endmodule

// File: rtl/bist_diag.sv
module bist_diag #(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic req,
    input  logic ack,
    input  logic ack_fail,
    output logic done,
    output logic fail
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT - 1);

    logic          active;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            fail   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                fail   <= 1'b0;
            end else if (active) begin
                if (ack) begin
                    active <= 1'b0;
                    fail   <= ack_fail;
                    done   <= 1'b1;
                end else if (cnt == LAST_CNT) begin
                    active <= 1'b0;
                    fail   <= 1'b1;
                    done   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign req = active;

endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter int               ROM_DEPTH    = 64,
    parameter int               REG_COUNT    = 8,
    parameter int               DIAG_TIMEOUT = 1024,
    parameter int               ADDR_W       = 32,
    parameter logic [SIG_W-1:0] GOOD_SIG     = 16'h0000,
    localparam int              ROM_AW       = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1,
    localparam int              REG_AW       = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              sel_rst,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    output logic              reg_we,
    output logic              reg_re,
    output logic [REG_AW-1:0] reg_sel,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              diag_req,
    input  logic              diag_ack,
    input  logic              diag_fail,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              full_rst
);

    localparam logic [ROM_AW-1:0] ROM_LAST = ROM_AW'(ROM_DEPTH - 1);

    seq_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic [ROM_AW-1:0] rom_idx;
    logic              rom_vld_q;
    logic              rom_fail_q;
    logic [SIG_W-1:0]  sig;
    logic              rc_start, rc_done, rc_fail;
    logic              dg_start, dg_done, dg_fail;
    fail_flags_t       flags;

    bist_misr u_misr (
        .clk   (clk),
        .rst   (rst),
        .load  (state == ST_SRST),
        .shift (rom_vld_q),
        .din   (rom_data),
        .sig   (sig)
    );

    assign rc_start = (state == ST_ROM_CMP);

    bist_reg_check #(
        .REG_COUNT (REG_COUNT),
        .REG_AW    (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .start     (rc_start),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (rc_done),
        .fail      (rc_fail)
    );

    assign dg_start = (state == ST_REGS) && rc_done;

    bist_diag #(
        .TIMEOUT (DIAG_TIMEOUT)
    ) u_diag (
        .clk      (clk),
        .rst      (rst),
        .start    (dg_start),
        .req      (diag_req),
        .ack      (diag_ack),
        .ack_fail (diag_fail),
        .done     (dg_done),
        .fail     (dg_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            rom_idx    <= '0;
            rom_vld_q  <= 1'b0;
            rom_fail_q <= 1'b0;
        end else begin
            rom_vld_q <= (state == ST_ROM);
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        addr_q <= cmd_addr;
                        state  <= ST_SRST;
                    end
                end
                ST_SRST: begin
                    rom_idx <= '0;
                    state   <= ST_ROM;
                end
                ST_ROM: begin
                    if (rom_idx == ROM_LAST) begin
                        state <= ST_ROM_WAIT;
                    end else begin
                        rom_idx <= rom_idx + 1'b1;
                    end
                end
                ST_ROM_WAIT: state <= ST_ROM_CMP;
                ST_ROM_CMP: begin
                    rom_fail_q <= (sig != GOOD_SIG);
                    state      <= ST_REGS;
                end
                ST_REGS: begin
                    if (rc_done) begin
                        state <= ST_DIAG;
                    end
                end
                ST_DIAG: begin
                    if (dg_done) begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ready) begin
                        state <= ST_FRST;
                    end
                end
                ST_FRST: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        flags.rom  = rom_fail_q;
        flags.regs = rc_fail;
        flags.diag = dg_fail;
    end

    assign busy         = (state != ST_IDLE);
    assign sel_rst      = (state == ST_SRST);
    assign rom_rd       = (state == ST_ROM);
    assign rom_addr     = rom_idx;
    assign mem_wr_valid = (state == ST_WRITE);
    assign mem_wr_addr  = addr_q;
    assign mem_wr_data  = pack_result(flags, sig);
    assign full_rst     = (state == ST_FRST);

endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk #(
    parameter int ROM_AW       = 6,
    parameter int ADDR_W       = 32,
    parameter int DIAG_TIMEOUT = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              sel_rst,
    input logic              rom_rd,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              reg_we,
    input logic              reg_re,
    input logic              diag_req,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [31:0]       mem_wr_data,
    input logic              mem_wr_ready,
    input logic              full_rst
);

    int req_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_run <= 0;
        end else if (diag_req) begin
            req_run <= req_run + 1;
        end else begin
            req_run <= 0;
        end
    end

    // R2
    sel_rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sel_rst |=> !sel_rst);

    // R3
    rom_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rom_rd && $past(rom_rd)) |-> (rom_addr == $past(rom_addr) + 1'b1));

    // R5
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_rst, rom_rd, reg_we, reg_re, diag_req, mem_wr_valid, full_rst}));

    // R7
    diag_window_chk: assert property (@(posedge clk) disable iff (rst)
        diag_req |-> (req_run < DIAG_TIMEOUT));

    // R8
    low_half_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> ((mem_wr_data[15:0] & ~16'h102C) == 16'h0000));

    // R9
    general_flag_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> (mem_wr_data[12] == (mem_wr_data[2] | mem_wr_data[3] | mem_wr_data[5])));

    // R10
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R11
    full_rst_end_chk: assert property (@(posedge clk) disable iff (rst)
        full_rst |=> (!full_rst && !busy));

endmodule

bind bist_seq bist_seq_chk #(
    .ROM_AW       (ROM_AW),
    .ADDR_W       (ADDR_W),
    .DIAG_TIMEOUT (DIAG_TIMEOUT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .sel_rst      (sel_rst),
    .rom_rd       (rom_rd),
    .rom_addr     (rom_addr),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .diag_req     (diag_req),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ready (mem_wr_ready),
    .full_rst     (full_rst)
);

// File: tb/bist_seq_tb.sv
module bist_seq_tb;

    localparam int DEPTH = 64;
    localparam int NREG  = 8;
    localparam int TMO   = 1024;

    function automatic logic [15:0] rom_word(input int i);
        return 16'(i * 311) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] ref_sig(input bit corrupt);
        logic [15:0] s;
        logic [15:0] d;
        logic        fb;
        s = 16'hFFFF;
        for (int i = 0; i < DEPTH; i++) begin
            d = rom_word(i);
            if (corrupt && i == 17) d = d ^ 16'h0100;
            fb = s[15];
            s  = s << 1;
            if (fb) s = s ^ 16'h1021;
            s = s ^ d;
        end
        return s;
    endfunction

    localparam logic [15:0] GOOD = ref_sig(1'b0);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic        busy, sel_rst, rom_rd, reg_we, reg_re, diag_req;
    logic [5:0]  rom_addr;
    logic [2:0]  reg_sel;
    logic [15:0] rom_data, reg_wdata, reg_rdata;
    logic        diag_ack, diag_fail;
    logic        mem_wr_valid, mem_wr_ready, full_rst;
    logic [31:0] mem_wr_addr, mem_wr_data;

    always #10 clk = ~clk;

    bist_seq #(
        .ROM_DEPTH    (DEPTH),
        .REG_COUNT    (NREG),
        .DIAG_TIMEOUT (TMO),
        .ADDR_W       (32),
        .GOOD_SIG     (GOOD)
    ) u_dut (
        .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_addr (cmd_addr),
        .busy (busy), .sel_rst (sel_rst), .rom_rd (rom_rd), .rom_addr (rom_addr),
        .rom_data (rom_data), .reg_we (reg_we), .reg_re (reg_re), .reg_sel (reg_sel),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .diag_req (diag_req),
        .diag_ack (diag_ack), .diag_fail (diag_fail), .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data),
        .mem_wr_ready (mem_wr_ready), .full_rst (full_rst)
    );

    // run configuration
    bit          cfg_corrupt, cfg_stuck, cfg_noack, cfg_dfail;
    int          cfg_ddelay, cfg_wdelay;
    logic [31:0] cfg_addr;

    int checks = 0;
    int errors = 0;

    // bench-side models
    logic [15:0] rom_mem [DEPTH];
    logic [15:0] reg_mem [NREG];
    int          dcnt, wcnt;

    initial begin
        for (int i = 0; i < DEPTH; i++) rom_mem[i] = rom_word(i);
        for (int i = 0; i < NREG; i++) reg_mem[i] = 16'h0000;
    end

    always @(posedge clk) begin
        if (rom_rd) rom_data <= rom_mem[rom_addr] ^ ((cfg_corrupt && rom_addr == 6'd17) ? 16'h0100 : 16'h0000);
        if (reg_we) reg_mem[reg_sel] <= reg_wdata;
        if (reg_re) reg_rdata <= reg_mem[reg_sel] | ((cfg_stuck && reg_sel == 3'd3) ? 16'h0001 : 16'h0000);
        if (diag_req) dcnt <= dcnt + 1;
        if (mem_wr_valid && !mem_wr_ready) wcnt <= wcnt + 1;
    end

    assign diag_ack     = diag_req && !cfg_noack && (dcnt == cfg_ddelay);
    assign diag_fail    = cfg_dfail;
    assign mem_wr_ready = mem_wr_valid && (wcnt >= cfg_wdelay);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference model state, advanced on every clock
    bit          running = 1'b0;
    int          srst_cnt, rom_cnt, op_cnt, dreq_cnt, wr_cnt, frst_cnt;
    logic [31:0] exp_word;
    bit          prev_hold;
    logic [31:0] prev_addr, prev_data;

    always @(negedge clk) begin
        if (!rst && running) begin
            if (sel_rst) begin
                check(srst_cnt == 0 && rom_cnt == 0, "R2", "sel_rst first and once", srst_cnt, 0);
                srst_cnt++;
            end
            if (rom_rd) begin
                check(srst_cnt == 1, "R2", "ROM read after sel_rst", srst_cnt, 1);
                check(rom_addr == 6'(rom_cnt), "R3", "rom_addr", rom_addr, rom_cnt);
                rom_cnt++;
            end
            if (reg_we || reg_re) begin
                check(rom_cnt == DEPTH, "R5", "reg access after ROM scan", rom_cnt, DEPTH);
                check(reg_sel == 3'(op_cnt / 4), "R5", "reg_sel", reg_sel, op_cnt / 4);
                check(reg_we == (op_cnt % 2 == 0) && reg_re == (op_cnt % 2 == 1), "R5", "op kind",
                      {reg_we, reg_re}, (op_cnt % 2 == 0) ? 2 : 1);
                if (reg_we)
                    check(reg_wdata == ((op_cnt % 4 == 0) ? 16'h5555 : 16'hAAAA), "R5", "pattern",
                          reg_wdata, (op_cnt % 4 == 0) ? 16'h5555 : 16'hAAAA);
                op_cnt++;
            end
            if (diag_req) begin
                if (dreq_cnt == 0)
                    check(op_cnt == 4 * NREG, "R6", "diag after register check", op_cnt, 4 * NREG);
                dreq_cnt++;
            end
            if (prev_hold)
                check(mem_wr_valid && mem_wr_addr == prev_addr && mem_wr_data == prev_data,
                      "R10", "write held until ready", mem_wr_data, prev_data);
            if (mem_wr_valid) begin
                check(dreq_cnt > 0 && !diag_req, "R10", "write after diagnose", dreq_cnt, 1);
                if (mem_wr_ready) begin
                    check(mem_wr_addr == cfg_addr, "R1", "result address", mem_wr_addr, cfg_addr);
                    check(mem_wr_data[31:16] == exp_word[31:16], "R4", "signature half",
                          mem_wr_data[31:16], exp_word[31:16]);
                    check(mem_wr_data[15:0] == exp_word[15:0], "R8", "flag half",
                          mem_wr_data[15:0], exp_word[15:0]);
                    check(mem_wr_data[12] == exp_word[12], "R9", "general flag",
                          mem_wr_data[12], exp_word[12]);
                    wr_cnt++;
                end
            end
            prev_hold = mem_wr_valid && !mem_wr_ready;
            prev_addr = mem_wr_addr;
            prev_data = mem_wr_data;
            if (full_rst) begin
                check(wr_cnt == 1, "R11", "full_rst after write", wr_cnt, 1);
                frst_cnt++;
            end
        end
    end

    task automatic run_test(input logic [31:0] addr, input bit corrupt, input bit stuck,
                            input bit noack, input bit dfail, input int ddelay,
                            input int wdelay, input bit inject);
        logic rf, gf, df;
        @(negedge clk);
        cfg_addr = addr; cfg_corrupt = corrupt; cfg_stuck = stuck; cfg_noack = noack;
        cfg_dfail = dfail; cfg_ddelay = ddelay; cfg_wdelay = wdelay;
        dcnt = 0; wcnt = 0;
        srst_cnt = 0; rom_cnt = 0; op_cnt = 0; dreq_cnt = 0; wr_cnt = 0; frst_cnt = 0;
        prev_hold = 1'b0;
        rf = (ref_sig(corrupt) != GOOD);
        gf = stuck;
        df = noack | dfail;
        exp_word = {ref_sig(corrupt), 3'b000, rf | gf | df, 6'b000000, df, 1'b0, gf, rf, 2'b00};
        running  = 1'b1;
        cmd_valid = 1'b1;
        cmd_addr  = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (inject) begin
            repeat (20) @(negedge clk);
            cmd_valid = 1'b1;
            cmd_addr  = ~addr;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (frst_cnt == 0) @(negedge clk);
        @(negedge clk);
        check(!busy, "R11", "idle after full_rst", busy, 0);
        repeat (4) @(negedge clk);
        running = 1'b0;
        check(srst_cnt == 1, "R1", "single run per command", srst_cnt, 1);
        check(rom_cnt == DEPTH, "R3", "ROM reads", rom_cnt, DEPTH);
        check(op_cnt == 4 * NREG, "R5", "register accesses", op_cnt, 4 * NREG);
        if (noack)
            check(dreq_cnt == TMO, "R7", "diag_req cycles on timeout", dreq_cnt, TMO);
        else
            check(dreq_cnt == ddelay + 1, "R6", "diag_req cycles", dreq_cnt, ddelay + 1);
        check(wr_cnt == 1, "R10", "result writes", wr_cnt, 1);
        check(frst_cnt == 1, "R11", "full_rst pulses", frst_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !sel_rst && !rom_rd && !reg_we && !reg_re && !diag_req
              && !mem_wr_valid && !full_rst, "R12", "reset state",
              {busy, sel_rst, rom_rd, reg_we, reg_re, diag_req, mem_wr_valid, full_rst}, 0);
        // all checks pass
        run_test(32'h1000_0040, 1'b0, 1'b0, 1'b0, 1'b0, 5, 0, 1'b0);
        // ROM corrupted, write stalled
        run_test(32'h2000_0100, 1'b1, 1'b0, 1'b0, 1'b0, 0, 3, 1'b0);
        // register stuck bit, diagnose reports failure
        run_test(32'h3000_0200, 1'b0, 1'b1, 1'b0, 1'b1, 12, 1, 1'b0);
        // diagnose never answers, stray command mid-run
        run_test(32'h4000_0300, 1'b0, 1'b0, 1'b1, 1'b0, 0, 2, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule